// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Slave

This block is the device side of a bit-banged serial EEPROM that holds 256 words of 16 bits. A host drives three lines: a chip select, a serial clock and a data input. The block answers on one data-output line. The pins are sampled by the system clock through a short synchronizer. Edges of chip select and serial clock are found by comparing each sample with the one before it, so the host may toggle the lines at any rate below a few system clocks per phase.

A command frame is a start bit, a two-bit opcode and an eight-bit word address, sent most significant bit first. Some opcodes are followed by sixteen data bits. Opcode `00` is a group of special commands, selected by the two highest address bits: lock writes, unlock writes, fill every word with a value, or set every word to all ones. The other opcodes are single-word write, single-word read and single-word erase. A single-word write or erase is stored when chip select next rises, and only while writes are unlocked. After that rise the output reads 1, which the host takes as ready. Reads shift the stored word out on falling serial-clock edges. The storage is an internal register array. Reset sets every word to all ones and locks writes.

Top module: `tri_wire_eeprom`

## Requirements
- R1: While reset is held and after it is released, `do_o` is 1, writes are locked and every word reads 0xFFFF. A reset given after stored data also brings every word back to 0xFFFF and locks writes again.
- R2: A rising edge of `cs_i` puts the block in idle, except where R4 or R8 apply. In idle, serial-clock rising edges with `di_i` low are ignored, and the first one with `di_i` high is the start bit. It is followed by two opcode bits and then eight address bits, MSB first. A `cs_i` rise part-way through a frame abandons it, and a new frame can follow at once.
- R3: Read (opcode `10`): the serial-clock rising edge after the last address bit drives `do_o` to 0. Each of the next 16 falling edges then puts the next bit of the addressed word on `do_o`, MSB first.
- R4: Write (opcode `01`): the 16 data bits after the address, MSB first, are stored at that address on the next `cs_i` rise if writes are unlocked. After that rise `do_o` reads 1.
- R5: While writes are locked, a single-word write or erase leaves the stored word unchanged.
- R6: Opcode `00` with address bits [7:6] = `11` unlocks writes, and with `00` locks them. Either takes effect after the eighth address bit, with no data bits.
- R7: Erase (opcode `11`): after 16 more serial-clock rising edges, whose data is ignored, the addressed word becomes 0xFFFF on the next `cs_i` rise if writes are unlocked. Other words keep their values.
- R8: Opcode `00` with address bits [7:6] = `01`: after 16 data bits, every word takes that value if writes are unlocked. The following `cs_i` rise stores no further word and sets `do_o` to 1.
- R9: Opcode `00` with address bits [7:6] = `10`: after 16 more bits, every word becomes 0xFFFF if writes are unlocked.
- R10: While writes are locked, the two whole-array commands of R8 and R9 change no word.
- R11: A write frame cut off by a `cs_i` rise before its sixteenth data bit stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select; its rising edge frames commands and commits writes |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data and ready indication to the host |

## Verification
The assertions assume that the host changes the pins much more slowly than the system clock. They also assume that one serial-clock transition is never combined with a chip-select rise in the same sample, because the ordering properties for entering idle exclude that case. The stimulus changes one pin at a time and holds every level for five system clocks, more than the synchronizer and edge detector need. It always raises chip select with the serial clock low, so each rise is seen alone.

// File: rtl/twe_pkg.sv
package twe_pkg;

    // protocol states; the order is free, the shift rule uses twe_shifts()
    typedef enum logic [3:0] {
        ST_NULL,
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_SPECIAL,
        ST_WR_DATA,
        ST_RD_WAIT,
        ST_ER_DATA,
        ST_RD_OUT,
        ST_COMMIT,
        ST_BULK_DONE
    } twe_state_e;

    // opcode values as they arrive on the wire
    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } twe_op_e;

    // sub-command carried in the two top address bits of OP_SPECIAL
    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_CLEAR  = 2'b10,
        SUB_UNLOCK = 2'b11
    } twe_sub_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } twe_pins_t;

    typedef struct packed {
        logic cs_rise;
        logic sk_rise;
        logic sk_fall;
        logic di;
    } twe_evt_t;

    // states in which a rising serial clock shifts data in
    function automatic logic twe_shifts(twe_state_e s);
        return (s != ST_NULL) && (s != ST_IDLE) && (s != ST_RD_OUT);
    endfunction

endpackage

// File: rtl/twe_pin_sync.sv
module twe_pin_sync
    import twe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  twe_pins_t pins_i,
    output twe_evt_t  evt_o
);

    twe_pins_t cur;
    twe_pins_t prev_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign cur = pins_i;
        end else begin : g_chain
            twe_pins_t stg_q [SYNC_STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
                end else begin
                    stg_q[0] <= pins_i;
                    for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
                end
            end
            assign cur = stg_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    always_comb begin
        evt_o.cs_rise = cur.cs & ~prev_q.cs;
        evt_o.sk_rise = cur.sk & ~prev_q.sk;
        evt_o.sk_fall = ~cur.sk & prev_q.sk;
        evt_o.di      = cur.di;
    end

endmodule

// File: rtl/twe_word_store.sv
module twe_word_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (fill_en) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= fill_data;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/twe_ctrl.sv
module twe_ctrl
    import twe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  twe_evt_t          evt,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fill_en,
    output logic [DATA_W-1:0] fill_data,
    output logic              dout,
    output twe_state_e        state_o,
    output logic              wen_o
);

    localparam int SR_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] OP_BITS   = CNT_W'(2);
    localparam logic [CNT_W-1:0] ADDR_BITS = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DATA_BITS = CNT_W'(DATA_W);

    twe_state_e        st_q,   st_n;
    logic [SR_W-1:0]   sr_q,   sr_n;
    logic [CNT_W-1:0]  cnt_q,  cnt_n;
    twe_op_e           op_q,   op_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              wen_q,  wen_n;
    twe_sub_e          sub;

    always_comb begin
        st_n      = st_q;
        sr_n      = sr_q;
        cnt_n     = cnt_q;
        op_n      = op_q;
        addr_n    = addr_q;
        wen_n     = wen_q;
        wr_en     = 1'b0;
        wr_addr   = addr_q;
        wr_data   = sr_q[DATA_W-1:0];
        fill_en   = 1'b0;
        fill_data = sr_q[DATA_W-1:0];
        sub       = twe_sub_e'(addr_q[ADDR_W-1 -: 2]);

        // chip-select rise: commit a pending single-word store or restart
        if (evt.cs_rise) begin
            if (st_q == ST_COMMIT) begin
                wr_en = wen_q;
                sr_n  = '1;
                st_n  = ST_NULL;
            end else if (st_q == ST_BULK_DONE) begin
                sr_n  = '1;
                st_n  = ST_NULL;
            end else begin
                st_n  = ST_IDLE;
            end
        end

        if (evt.sk_rise) begin
            if (twe_shifts(st_n)) begin
                sr_n  = {sr_n[SR_W-2:0], evt.di};
                cnt_n = cnt_n + 1'b1;
            end
            case (st_n)
                ST_IDLE: begin
                    if (evt.di) begin
                        st_n  = ST_OPCODE;
                        cnt_n = '0;
                        sr_n  = '0;
                    end
                end
                ST_OPCODE: begin
                    if (cnt_n == OP_BITS) begin
                        st_n  = ST_ADDR;
                        cnt_n = '0;
                        op_n  = twe_op_e'(sr_n[1:0]);
                    end
                end
                ST_ADDR: begin
                    if (cnt_n == ADDR_BITS) begin
                        cnt_n  = '0;
                        addr_n = sr_n[ADDR_W-1:0];
                        case (op_n)
                            OP_SPECIAL: begin
                                case (twe_sub_e'(addr_n[ADDR_W-1 -: 2]))
                                    SUB_LOCK: begin
                                        wen_n = 1'b0;
                                        st_n  = ST_NULL;
                                    end
                                    SUB_UNLOCK: begin
                                        wen_n = 1'b1;
                                        st_n  = ST_NULL;
                                    end
                                    default: st_n = ST_SPECIAL;
                                endcase
                            end
                            OP_WRITE: st_n = ST_WR_DATA;
                            OP_READ:  st_n = ST_RD_WAIT;
                            default:  st_n = ST_ER_DATA;
                        endcase
                    end
                end
                ST_SPECIAL: begin
                    if (cnt_n == DATA_BITS) begin
                        cnt_n = '0;
                        st_n  = ST_BULK_DONE;
                        if (sub == SUB_FILL) begin
                            fill_en   = wen_q;
                            fill_data = sr_n[DATA_W-1:0];
                        end else begin
                            fill_en   = wen_q;
                            fill_data = '1;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (cnt_n == DATA_BITS) begin
                        cnt_n = '0;
                        st_n  = ST_COMMIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (cnt_n == CNT_W'(1)) begin
                        sr_n  = {1'b0, rd_data};
                        cnt_n = '0;
                        st_n  = ST_RD_OUT;
                    end
                end
                ST_ER_DATA: begin
                    if (cnt_n == DATA_BITS) begin
                        sr_n  = {1'b0, {DATA_W{1'b1}}};
                        cnt_n = '0;
                        st_n  = ST_COMMIT;
                    end
                end
                default: ;
            endcase
        end else if (evt.sk_fall && st_n == ST_RD_OUT) begin
            sr_n  = {sr_n[SR_W-2:0], 1'b0};
            cnt_n = cnt_n + 1'b1;
            if (cnt_n == DATA_BITS) begin
                cnt_n = '0;
                st_n  = ST_NULL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_NULL;
            sr_q   <= '1;
            cnt_q  <= '0;
            op_q   <= OP_SPECIAL;
            addr_q <= '0;
            wen_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            sr_q   <= sr_n;
            cnt_q  <= cnt_n;
            op_q   <= op_n;
            addr_q <= addr_n;
            wen_q  <= wen_n;
        end
    end

    assign rd_addr = addr_q;
    assign dout    = sr_q[SR_W-1];
    assign state_o = st_q;
    assign wen_o   = wen_q;

endmodule

// File: rtl/tri_wire_eeprom.sv
module tri_wire_eeprom
    import twe_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o
);

    twe_pins_t         pins;
    twe_evt_t          evt;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              fill_en;
    logic [DATA_W-1:0] fill_data;
    twe_state_e        st;
    logic              wen;

    assign pins = {cs_i, sk_i, di_i};

    twe_pin_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins),
        .evt_o  (evt)
    );

    twe_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fill_en   (fill_en),
        .fill_data (fill_data),
        .dout      (do_o),
        .state_o   (st),
        .wen_o     (wen)
    );

    twe_word_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fill_en   (fill_en),
        .fill_data (fill_data)
    );

endmodule

// File: rtl/twe_chk.sv
module twe_chk
    import twe_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       do_o,
    input twe_state_e state,
    input logic       wen,
    input logic       cs_rise,
    input logic       sk_rise,
    input logic       wr_en,
    input logic       fill_en
);

    // R1: output reads ready after a reset cycle
    a_r1_ready_after_reset: assert property (@(posedge clk)
        rst |=> do_o);

    // R2: a chip-select rise with nothing pending lands in idle
    a_r2_cs_to_idle: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !sk_rise && state != ST_COMMIT && state != ST_BULK_DONE)
        |=> state == ST_IDLE);

    // R4: the rise that closes a store leaves the output high
    a_r4_ready_after_commit: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && (state == ST_COMMIT || state == ST_BULK_DONE)) |=> do_o);

    // R5: a single-word store only happens on a commit while unlocked
    a_r5_store_needs_unlock: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (cs_rise && state == ST_COMMIT && wen));

    // R6: the lock flag only moves at the end of an address field
    a_r6_lock_source: assert property (@(posedge clk) disable iff (rst)
        !$stable(wen) |-> $past(state) == ST_ADDR);

    // R8: whole-array fills come from the special group while unlocked
    a_r8_fill_source: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (wen && state == ST_SPECIAL && !wr_en));

endmodule

bind tri_wire_eeprom twe_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .do_o    (do_o),
    .state   (st),
    .wen     (wen),
    .cs_rise (evt.cs_rise),
    .sk_rise (evt.sk_rise),
    .wr_en   (wr_en),
    .fill_en (fill_en)
);

// File: tb/sim_tri_wire_eeprom.sv
module sim_tri_wire_eeprom;

    localparam int PH = 5;        // system clocks per pin level
    localparam logic [3:0] K_UNLOCK = 4'd0;
    localparam logic [3:0] K_LOCK   = 4'd1;
    localparam logic [3:0] K_WRITE  = 4'd2;
    localparam logic [3:0] K_READ   = 4'd3;
    localparam logic [3:0] K_ERASE  = 4'd4;
    localparam logic [3:0] K_FILL   = 4'd5;
    localparam logic [3:0] K_CLEAR  = 4'd6;
    localparam int NVEC = 22;

    // {kind, requirement number, address, data or expected word}
    localparam logic [31:0] VEC [NVEC] = '{
        {K_READ,   4'd1,  8'h00, 16'hFFFF},  // R1 erased after reset
        {K_WRITE,  4'd5,  8'h05, 16'h1234},  // R5 locked write
        {K_READ,   4'd5,  8'h05, 16'hFFFF},  // R5
        {K_UNLOCK, 4'd6,  8'h00, 16'h0000},  // R6
        {K_WRITE,  4'd4,  8'h05, 16'hA5C3},  // R4
        {K_READ,   4'd4,  8'h05, 16'hA5C3},  // R4
        {K_WRITE,  4'd4,  8'hFF, 16'h0F0F},  // R4 top address
        {K_READ,   4'd4,  8'hFF, 16'h0F0F},  // R4
        {K_ERASE,  4'd7,  8'h05, 16'h0000},  // R7
        {K_READ,   4'd7,  8'h05, 16'hFFFF},  // R7
        {K_READ,   4'd7,  8'hFF, 16'h0F0F},  // R7 neighbour kept
        {K_FILL,   4'd8,  8'h00, 16'h3C3C},  // R8
        {K_READ,   4'd8,  8'h80, 16'h3C3C},  // R8
        {K_READ,   4'd8,  8'h00, 16'h3C3C},  // R8
        {K_CLEAR,  4'd9,  8'h00, 16'h0000},  // R9
        {K_READ,   4'd9,  8'h7F, 16'hFFFF},  // R9
        {K_LOCK,   4'd6,  8'h00, 16'h0000},  // R6
        {K_FILL,   4'd10, 8'h00, 16'h1111},  // R10
        {K_READ,   4'd10, 8'h33, 16'hFFFF},  // R10
        {K_WRITE,  4'd5,  8'h33, 16'h0001},  // R5
        {K_ERASE,  4'd5,  8'h33, 16'h0000},  // R5
        {K_READ,   4'd5,  8'h33, 16'hFFFF}   // R5
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_i = 1'b0;
    logic sk_i = 1'b0;
    logic di_i = 1'b0;
    logic do_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    tri_wire_eeprom u0 (
        .clk  (clk),
        .rst  (rst),
        .cs_i (cs_i),
        .sk_i (sk_i),
        .di_i (di_i),
        .do_o (do_o)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic d);
        @(negedge clk);
        cs_i = c;
        sk_i = s;
        di_i = d;
        repeat (PH) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        step(1'b1, 1'b0, b);
        step(1'b1, 1'b1, b);
    endtask

    task automatic begin_cmd();
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [7:0] a);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic commit(input string tag);
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check(do_o == 1'b1, tag, {31'd0, do_o}, 32'd1);
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] w;
        w = '0;
        begin_cmd();
        send_hdr(2'b10, a);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        check(do_o == 1'b0, "R3 leading zero", {31'd0, do_o}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, 1'b0);
            w = {w[14:0], do_o};
            step(1'b1, 1'b1, 1'b0);
        end
        check(w == exp, tag, {16'd0, w}, {16'd0, exp});
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_vec(input logic [31:0] v);
        string tag;
        tag = $sformatf("R%0d vector", v[27:24]);
        case (v[31:28])
            K_UNLOCK: begin begin_cmd(); send_hdr(2'b00, 8'hC0); step(1'b0, 1'b0, 1'b0); end
            K_LOCK:   begin begin_cmd(); send_hdr(2'b00, 8'h00); step(1'b0, 1'b0, 1'b0); end
            K_WRITE:  begin begin_cmd(); send_hdr(2'b01, v[23:16]); send_word(v[15:0]); commit("R4 ready"); end
            K_ERASE:  begin begin_cmd(); send_hdr(2'b11, v[23:16]); send_word(16'h0000); commit("R4 ready"); end
            K_FILL:   begin begin_cmd(); send_hdr(2'b00, 8'h40); send_word(v[15:0]); commit("R8 ready"); end
            K_CLEAR:  begin begin_cmd(); send_hdr(2'b00, 8'h80); send_word(16'h0000); commit("R8 ready"); end
            default:  do_read(v[23:16], v[15:0], tag);
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(do_o == 1'b1, "R1 ready in reset", {31'd0, do_o}, 32'd1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(do_o == 1'b1, "R1 ready after reset", {31'd0, do_o}, 32'd1);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R2: leading zeros before the start bit are skipped
        run_vec({K_UNLOCK, 4'd6, 8'h00, 16'h0000});
        begin_cmd();
        send_bit(1'b0);
        send_bit(1'b0);
        send_hdr(2'b01, 8'h21);
        send_word(16'hBEEF);
        commit("R4 ready");
        do_read(8'h21, 16'hBEEF, "R2 leading zeros");

        // R11: cut-off write stores nothing, R2: next frame works at once
        begin_cmd();
        send_hdr(2'b01, 8'h10);
        send_word(16'h00AA);
        begin_cmd();
        send_hdr(2'b01, 8'h10);
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        step(1'b0, 1'b0, 1'b0);
        do_read(8'h10, 16'h00AA, "R11 cut-off write");
        begin_cmd();
        send_hdr(2'b10, 8'h21);
        send_bit(1'b0);
        do_read(8'h21, 16'hBEEF, "R2 abandoned read then new frame");

        // R1: reset clears stored data and locks writes
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        do_read(8'h21, 16'hFFFF, "R1 reset clears words");
        run_vec({K_WRITE, 4'd1, 8'h22, 16'h5555});
        do_read(8'h22, 16'hFFFF, "R1 locked after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule